// File: doc/BRIEF.md
# Shared-Memory Data-Path Sequencer

This block sits between a central sequencing controller, a shared memory bus and one hardware computation unit. It waits until the controller's state code selects execution. It then runs a fixed schedule of invocations on the computation unit. For each invocation it reads two operands from memory over the shared bus and holds them on the unit's inputs. It fires a start pulse, waits for the unit to report completion, captures the unit's result and writes that result back to memory.

Invocation `k`, counted from 0, reads its first operand at `BASE_IN + 2k` and its second at `BASE_IN + 2k + 1`. It stores its result at `BASE_OUT + k`. The invocation count, both base addresses, the execution code and the wait limit are parameters.

After the last write the block raises a one-cycle completion pulse. It then stays quiet until the controller's code has left the execution value and come back to it. A watchdog guards each wait for the computation unit. If the unit stays silent for too long, the block flags an error and abandons the schedule.

Top module: `dp_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mem_req`, `mem_we`, `dp_start`, `dp_finished` and `wd_error` are all low.
- R2: When armed and `ctl_state` equals `EXEC_CODE` (default 2), the block reads the first operand of invocation k from `BASE_IN + 2k`, and then the second from `BASE_IN + 2k + 1`. A bus transfer completes in a cycle where `mem_req` and `mem_gnt` are both high, and read data on `mem_rdata` is taken in that cycle. `mem_req` stays high until the grant arrives.
- R3: Once both operands are loaded, `dp_start` is high for exactly one cycle.
- R4: `dp_op_a` holds the first operand and `dp_op_b` the second. Both stay unchanged from the start pulse until `dp_done` is accepted.
- R5: The `dp_result` value present when `dp_done` is accepted is written to `BASE_OUT + k`. The write is a bus transfer with `mem_we` high and the value on `mem_wdata`.
- R6: Invocations run in order k = 0 .. `N_INV`-1. After the last result write, `dp_finished` is high for exactly one cycle and the block returns to idle.
- R7: After a completed schedule, or after a watchdog error, the block ignores `ctl_state` until it has held a value other than `EXEC_CODE` for at least one cycle.
- R8: Once a schedule has begun, changes on `ctl_state` neither abort nor pause it.
- R9: `dp_done` is accepted if it is high in any of the first `WD_LIMIT` cycles after the start pulse. Otherwise `wd_error` rises, the current result is not written, `dp_finished` is not pulsed, and the block returns to idle.
- R10: `wd_error` stays high until the next schedule begins. The cycle after an activation is taken, it is low.
- R11: `dp_done` is ignored while the block is not waiting on the computation unit. It causes no bus traffic and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_state | input | STATE_W | State code from the sequencing controller |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | Transfer is a write when high |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Transfer completes this cycle |
| mem_rdata | input | DATA_W | Read data, valid with the grant |
| dp_op_a | output | DATA_W | First operand to the computation unit |
| dp_op_b | output | DATA_W | Second operand to the computation unit |
| dp_start | output | 1 | One-cycle start pulse |
| dp_done | input | 1 | Computation unit finished |
| dp_result | input | DATA_W | Computation unit result, valid with `dp_done` |
| dp_finished | output | 1 | One-cycle pulse after the last write |
| wd_error | output | 1 | Computation unit failed to answer in time |

## Verification
The bench sweeps every unit latency from one cycle up to `WD_LIMIT` under three bus-grant patterns. This catches an off-by-one in the wait window, which would reject the slowest legal answer. It also catches a read that samples data before the grant, which would store results computed from stale operands. One latency past the limit must trip the watchdog with no result written and no completion pulse; a design that still wrote would leave the sentinel overwritten. The bench also holds the execution code steady after a schedule, drops it in the middle of a schedule, and pulses `dp_done` while idle. A block that re-triggers, aborts or reacts to a stray done would show extra start pulses, missing results or unexpected bus requests.

// File: rtl/dp_seq_pkg.sv
package dp_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH_A,
        SQ_FETCH_B,
        SQ_KICK,
        SQ_WAIT,
        SQ_STORE,
        SQ_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        BUS_NONE,
        BUS_READ,
        BUS_WRITE
    } bus_op_e;

    function automatic bus_op_e bus_op_of(input seq_state_e s);
        case (s)
            SQ_FETCH_A, SQ_FETCH_B: return BUS_READ;
            SQ_STORE:               return BUS_WRITE;
            default:                return BUS_NONE;
        endcase
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dp_seq_addr_gen.sv
module dp_seq_addr_gen #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned BASE_IN  = 16,
    parameter int unsigned BASE_OUT = 64
) (
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              second,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] IN_BASE  = ADDR_W'(BASE_IN);
    localparam logic [ADDR_W-1:0] OUT_BASE = ADDR_W'(BASE_OUT);

    logic [ADDR_W-1:0] idx_ext;

    always_comb begin
        idx_ext = ADDR_W'(inv_idx);
        rd_addr = IN_BASE + (idx_ext << 1) + ADDR_W'(second);
        wr_addr = OUT_BASE + idx_ext;
    end
endmodule

// File: rtl/dp_seq_watchdog.sv
module dp_seq_watchdog #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> (int'(cnt_q) < int'(LIMIT)));
endmodule

// File: rtl/dp_seq_operands.sv
module dp_seq_operands #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_a,
    input  logic              load_b,
    input  logic              load_res,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] result_in,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
            res  <= '0;
        end else begin
            if (load_a)   op_a <= rdata;
            if (load_b)   op_b <= rdata;
            if (load_res) res  <= result_in;
        end
    end
endmodule

// File: rtl/dp_sequencer.sv
module dp_sequencer
    import dp_seq_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned STATE_W   = 3,
    parameter int unsigned EXEC_CODE = 2,
    parameter int unsigned N_INV     = 3,
    parameter int unsigned BASE_IN   = 16,
    parameter int unsigned BASE_OUT  = 64,
    parameter int unsigned WD_LIMIT  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] ctl_state,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_gnt,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  dp_op_a,
    output logic [DATA_W-1:0]  dp_op_b,
    output logic               dp_start,
    input  logic               dp_done,
    input  logic [DATA_W-1:0]  dp_result,
    output logic               dp_finished,
    output logic               wd_error
);
    localparam int unsigned IDX_W = idx_width(N_INV);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_INV - 1);
    localparam logic [STATE_W-1:0] GO_CODE = STATE_W'(EXEC_CODE);

    seq_state_e        state_q, state_d;
    bus_op_e           bus_op;
    logic [IDX_W-1:0]  inv_q;
    logic              armed_q;
    logic              err_q;
    logic              xfer;
    logic              timeout;
    logic              take_go;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] res_q;

    assign bus_op  = bus_op_of(state_q);
    assign mem_req = (bus_op != BUS_NONE);
    assign mem_we  = (bus_op == BUS_WRITE);
    assign xfer    = mem_req && mem_gnt;
    assign take_go = (state_q == SQ_IDLE) && armed_q && (ctl_state == GO_CODE);

    dp_seq_addr_gen #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .BASE_IN (BASE_IN),
        .BASE_OUT(BASE_OUT)
    ) u_addr (
        .inv_idx(inv_q),
        .second (state_q == SQ_FETCH_B),
        .rd_addr(rd_addr),
        .wr_addr(wr_addr)
    );

    dp_seq_watchdog #(
        .LIMIT(WD_LIMIT)
    ) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clear  (state_q == SQ_KICK),
        .run    (state_q == SQ_WAIT && !dp_done),
        .expired(timeout)
    );

    dp_seq_operands #(
        .DATA_W(DATA_W)
    ) u_ops (
        .clk      (clk),
        .rst      (rst),
        .load_a   (state_q == SQ_FETCH_A && mem_gnt),
        .load_b   (state_q == SQ_FETCH_B && mem_gnt),
        .load_res (state_q == SQ_WAIT && dp_done),
        .rdata    (mem_rdata),
        .result_in(dp_result),
        .op_a     (dp_op_a),
        .op_b     (dp_op_b),
        .res      (res_q)
    );

    assign mem_addr    = mem_we ? wr_addr : rd_addr;
    assign mem_wdata   = res_q;
    assign dp_start    = (state_q == SQ_KICK);
    assign dp_finished = (state_q == SQ_FINISH);
    assign wd_error    = err_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:    if (take_go) state_d = SQ_FETCH_A;
            SQ_FETCH_A: if (xfer) state_d = SQ_FETCH_B;
            SQ_FETCH_B: if (xfer) state_d = SQ_KICK;
            SQ_KICK:    state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (dp_done)      state_d = SQ_STORE;
                else if (timeout) state_d = SQ_IDLE;
            end
            SQ_STORE: begin
                if (xfer) state_d = (inv_q == LAST_IDX) ? SQ_FINISH : SQ_FETCH_A;
            end
            SQ_FINISH:  state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            inv_q   <= '0;
            armed_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_go) begin
                inv_q <= '0;
                err_q <= 1'b0;
            end else if (state_q == SQ_STORE && xfer && inv_q != LAST_IDX) begin
                inv_q <= inv_q + 1'b1;
            end
            if (state_q == SQ_WAIT && !dp_done && timeout) begin
                err_q <= 1'b1;
            end
            if (state_q == SQ_FINISH || (state_q == SQ_WAIT && !dp_done && timeout)) begin
                armed_q <= 1'b0;
            end else if (ctl_state != GO_CODE) begin
                armed_q <= 1'b1;
            end
        end
    end

    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);

    a_r4_operands_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT) |-> ($stable(dp_op_a) && $stable(dp_op_b)));

    a_r6_finish_single: assert property (@(posedge clk) disable iff (rst)
        dp_finished |=> !dp_finished);

    a_r2_read_window: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |->
            (int'(mem_addr) >= int'(BASE_IN) && int'(mem_addr) < int'(BASE_IN + 2 * N_INV)));

    a_r5_write_window: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |->
            (int'(mem_addr) >= int'(BASE_OUT) && int'(mem_addr) < int'(BASE_OUT + N_INV)));

    a_r9_error_after_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_error) |-> ($past(state_q) == SQ_WAIT && !mem_req));

    a_r6_finish_after_write: assert property (@(posedge clk) disable iff (rst)
        dp_finished |-> ($past(mem_req) && $past(mem_we)));
endmodule

// File: tb/test_dp_sequencer.sv
module test_dp_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int SW = 3;
    localparam int EXEC = 2;
    localparam int NI = 3;
    localparam int BIN = 16;
    localparam int BOUT = 64;
    localparam int WDL = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] ctl_state = '0;
    logic          mem_req, mem_we, mem_gnt, dp_start, dp_done, dp_finished, wd_error;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dp_op_a, dp_op_b;
    logic [DW-1:0] dp_result = '0;

    logic [DW-1:0] mem [256];
    logic          gnt_en = 1'b1;
    int            gnt_mode = 0;
    int            lat_cfg = 1;
    int            rem = 0;
    logic          model_done = 1'b0;
    logic          extra_done = 1'b0;
    logic          busy = 1'b0;
    logic [DW-1:0] cap_a = '0, cap_b = '0;
    int            cyc = 0;
    int            starts = 0, fins = 0, reqs = 0, unstable = 0;
    int            checks = 0, errors = 0;
    bit            timed_out = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dp_sequencer #(
        .DATA_W(DW), .ADDR_W(AW), .STATE_W(SW), .EXEC_CODE(EXEC),
        .N_INV(NI), .BASE_IN(BIN), .BASE_OUT(BOUT), .WD_LIMIT(WDL)
    ) i_dp_sequencer (
        .clk(clk), .rst(rst), .ctl_state(ctl_state),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .dp_op_a(dp_op_a), .dp_op_b(dp_op_b), .dp_start(dp_start),
        .dp_done(dp_done), .dp_result(dp_result),
        .dp_finished(dp_finished), .wd_error(wd_error)
    );

    function automatic logic [DW-1:0] unit_fn(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return DW'((int'(a) * 3 + int'(b)) ^ 8'h5A);
    endfunction

    assign mem_gnt   = mem_req && gnt_en;
    assign mem_rdata = mem[mem_addr];
    assign dp_done   = model_done || extra_done;

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;
    end

    // computation unit model: done is seen by the design lat_cfg edges after the start edge
    always @(posedge clk) begin
        if (dp_start) begin
            cap_a <= dp_op_a;
            cap_b <= dp_op_b;
            busy  <= 1'b1;
            rem   <= lat_cfg - 1;
            model_done <= (lat_cfg == 1);
            if (lat_cfg == 1) dp_result <= unit_fn(dp_op_a, dp_op_b);
        end else if (rem != 0) begin
            rem <= rem - 1;
            model_done <= (rem == 1);
            if (rem == 1) dp_result <= unit_fn(cap_a, cap_b);
        end else begin
            if (model_done) busy <= 1'b0;
            model_done <= 1'b0;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        case (gnt_mode)
            0:       gnt_en <= 1'b1;
            1:       gnt_en <= cyc[0];
            default: gnt_en <= (cyc % 3 == 2);
        endcase
        if (dp_start)    starts <= starts + 1;
        if (dp_finished) fins <= fins + 1;
        if (mem_req)     reqs <= reqs + 1;
        if (busy && !dp_start && (dp_op_a != cap_a || dp_op_b != cap_b)) unstable <= unstable + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk);
        starts = 0; fins = 0; reqs = 0; unstable = 0;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 2 * NI; i++) mem[BIN + i] = DW'(seed * 37 + i * 11 + 1);
        for (int k = 0; k < NI; k++) mem[BOUT + k] = 8'hEE;
    endtask

    task automatic wait_end(input bit drop_mid);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (drop_mid && i == 4) ctl_state = '0;
            if (fins > 0 || wd_error) return;
        end
    endtask

    task automatic good_run(input int lat, input int mode, input int seed, input bit drop_mid, input string tag);
        ctl_state = '0;
        lat_cfg = lat;
        gnt_mode = mode;
        fill(seed);
        cycles(2);
        clear_counts();
        ctl_state = SW'(EXEC);
        wait_end(drop_mid);
        check({tag, " R6 finish pulse count"}, 32'(fins), 32'd1);
        check({tag, " R3 start pulses"}, 32'(starts), 32'(NI));
        check({tag, " R4 operands stable"}, 32'(unstable), 32'd0);
        for (int k = 0; k < NI; k++)
            check({tag, " R2 R5 stored result"}, 32'(mem[BOUT + k]),
                  32'(unit_fn(mem[BIN + 2 * k], mem[BIN + 2 * k + 1])));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        cycles(3);
        check("R1 reset req", 32'(mem_req), 0);
        check("R1 reset start", 32'(dp_start), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset outputs", 32'({mem_req, mem_we, dp_start, dp_finished, wd_error}), 0);

        // R2 R3 R5 R6: every legal latency against every grant pattern
        for (int m = 0; m < 3; m++)
            for (int l = 1; l <= WDL; l++)
                good_run(l, m, m * 16 + l, 1'b0, "sweep");

        // R7: code held at the execution value after completion starts nothing
        clear_counts();
        cycles(20);
        check("R7 no re-trigger while held", 32'(reqs), 0);
        check("R7 no start while held", 32'(starts), 0);

        // R8: dropping the code mid schedule does not abort it
        good_run(3, 1, 99, 1'b1, "R8 drop mid");

        // R11: stray done while idle
        ctl_state = '0;
        lat_cfg = 1;
        fill(7);
        clear_counts();
        for (int i = 0; i < 4; i++) begin
            extra_done = 1'b1; @(negedge clk);
            extra_done = 1'b0; @(negedge clk);
        end
        check("R11 stray done no request", 32'(reqs), 0);
        check("R11 stray done no write", 32'(mem[BOUT]), 32'hEE);

        // R9: one cycle beyond the limit trips the watchdog
        lat_cfg = WDL + 1;
        gnt_mode = 0;
        fill(3);
        cycles(2);
        clear_counts();
        ctl_state = SW'(EXEC);
        wait_end(1'b0);
        @(negedge clk);
        check("R9 error raised", 32'(wd_error), 1);
        check("R9 no finish pulse", 32'(fins), 0);
        check("R9 result not written", 32'(mem[BOUT]), 32'hEE);
        check("R9 single start", 32'(starts), 1);
        check("R9 back to idle", 32'(mem_req), 0);

        // R10 R7: error persists, no restart while code held
        clear_counts();
        cycles(12);
        check("R10 error held", 32'(wd_error), 1);
        check("R7 no restart after timeout", 32'(reqs), 0);
        ctl_state = '0;
        cycles(2);
        check("R10 error held while code away", 32'(wd_error), 1);
        lat_cfg = 2;
        fill(5);
        clear_counts();
        ctl_state = SW'(EXEC);
        cycles(2);
        check("R10 error cleared by new activation", 32'(wd_error), 0);
        wait_end(1'b0);
        check("R10 run after error finishes", 32'(fins), 1);
        for (int k = 0; k < NI; k++)
            check("R10 R5 result after error", 32'(mem[BOUT + k]),
                  32'(unit_fn(mem[BIN + 2 * k], mem[BIN + 2 * k + 1])));

        ctl_state = '0;
        cycles(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        timed_out = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule